// File: doc/BRIEF.md
# Adaptive Subsample Mask Controller

This block sits in front of a block-matching motion estimation array and decides, for every 16x16 macroblock, which of the 256 processing elements take part in the distortion sum. It receives a one-bit-per-pixel edge map from an upstream gradient stage. Every pixel marked as an edge is kept. Every other pixel is kept only if its position in a fixed interleaved visiting order falls below a threshold.

The threshold is steered once per frame by a proportional feedback loop. Across the frame the block adds up how many mask bits it set. At the frame boundary it divides that sum by the number of blocks per frame to get a per-block average. It then moves the threshold by about 0.2 times the gap between a software-supplied target and that average. The result is a kept-pixel count, and so an array power, that holds steady across very different video content.

The gain is implemented in fixed point as (err*13)>>6, which is 0.203, close to 0.2. The threshold starts fully open, so the first frame after reset runs at full quality.

Top module: `ssc_subsample_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `thresh_o` reads 256 and `mask_valid_o` is 0.
- R2: Every mask bit whose edge-map bit was 1 in the matching input block is 1, whatever the threshold.
- R3: Bit i of the map and mask is pixel (row = i/16, col = i%16). A non-edge pixel gets mask bit 1 exactly when its rank is below the threshold. Rank = ((row%2)*2 + col%2)*64 + (row/2)*8 + col/2, so the visiting order is even-row/even-col, then even-row/odd-col, then odd-row/even-col, then odd/odd. A threshold of 256 keeps all pixels and 0 keeps only the edges.
- R4: `mask_valid_o` is high exactly one cycle after `blk_valid_i`. The mask uses the threshold in force during the `blk_valid_i` cycle, which is the threshold before any update at that clock edge.
- R5: A frame's measurement is the sum of set bits over every mask shown with `mask_valid_o` after the previous frame boundary, up to and including the `frame_end_i` cycle. That sum is shifted right by 4 (16 blocks per frame) and capped at 256.
- R6: On `frame_end_i` the threshold becomes th + floor((tgt - avg)*13/64), saturated to 0..256, and appears on `thresh_o` in the next cycle. In all other cycles it holds.
- R7: `thresh_o` never exceeds 256.
- R8: A `target_i` above 256 acts as 256.
- R9: When edge pixels lie only on even-row/even-col positions and the target steps down by 48, the per-block kept average is within 5% of the target from the tenth frame after the step onward.
- R10: With no edges and a settled threshold of 64, the mask keeps exactly the even-row/even-col pixels, a 4-to-1 subsample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_valid_i | input | 1 | Edge map for one macroblock is present |
| edge_map_i | input | 256 | One edge flag per pixel |
| target_i | input | 9 | Desired kept pixels per block |
| frame_end_i | input | 1 | Closes the frame measurement and updates the threshold |
| mask_o | output | 256 | Processing-element enable per pixel |
| mask_valid_o | output | 1 | `mask_o` carries a new block |
| thresh_o | output | 9 | Threshold currently applied |

## Verification
The stress point is the frame boundary. There, a frame close and block traffic share a cycle, either the last block's mask being counted or the next block's mask being built. The bench always raises `frame_end_i` in the same cycle that the final block's mask is shown, so that mask must be counted in the closing frame. In later phases it also presents the next frame's first edge map in that same cycle, so that block must be masked with the threshold from before the update. A cycle-by-cycle behavioural model predicts both outcomes, and any misplaced count or early threshold shows up as a mask or threshold mismatch within a cycle or two.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  // Position of a pixel in the interleaved visiting order: parity class
  // first (even/even, even/odd, odd/even, odd/odd), then raster order
  // inside the class on the half-resolution grid.
  function automatic int pix_rank(input int idx, input int dim);
    int r;
    int c;
    int quarter;
    int half;
    r       = idx / dim;
    c       = idx % dim;
    quarter = (dim * dim) / 4;
    half    = dim / 2;
    return ((r % 2) * 2 + (c % 2)) * quarter + (r / 2) * half + (c / 2);
  endfunction

endpackage

// File: rtl/ssc_popcount.sv
module ssc_popcount #(
  parameter int N = 256,
  parameter int W = $clog2(N) + 1
) (
  input  logic [N-1:0] bits,
  output logic [W-1:0] count
);

  always_comb begin
    count = '0;
    for (int i = 0; i < N; i++) begin
      count = count + W'(bits[i]);
    end
  end

endmodule

// File: rtl/ssc_mask_stage.sv
module ssc_mask_stage #(
  parameter int DIM  = 16,
  parameter int NPIX = DIM * DIM,
  parameter int TH_W = $clog2(NPIX) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blk_valid,
  input  logic [NPIX-1:0] edge_map,
  input  logic [TH_W-1:0] thresh,
  output logic [NPIX-1:0] mask_q,
  output logic            valid_q,
  output logic [TH_W-1:0] kept_q
);

  logic [NPIX-1:0] keep;
  logic [TH_W-1:0] keep_cnt;

  // One comparator per pixel against a constant rank.
  for (genvar i = 0; i < NPIX; i++) begin : g_pix
    localparam int              RANK   = ssc_pkg::pix_rank(i, DIM);
    localparam logic [TH_W-1:0] RANK_V = TH_W'(RANK);
    assign keep[i] = edge_map[i] | (RANK_V < thresh);
  end

  // Count kept bits before the register so the loop stage sees a flop.
  ssc_popcount #(.N(NPIX), .W(TH_W)) u_pop (
    .bits  (keep),
    .count (keep_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
      kept_q  <= '0;
    end else begin
      valid_q <= blk_valid;
      if (blk_valid) begin
        mask_q <= keep;
        kept_q <= keep_cnt;
      end
    end
  end

endmodule

// File: rtl/ssc_loop_ctrl.sv
module ssc_loop_ctrl #(
  parameter int NPIX       = 256,
  parameter int TH_W       = $clog2(NPIX) + 1,
  parameter int FRM_LOG2   = 4,
  parameter int GAIN_NUM   = 13,
  parameter int GAIN_SHIFT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_end,
  input  logic            cnt_valid,
  input  logic [TH_W-1:0] cnt,
  input  logic [TH_W-1:0] target,
  output logic [TH_W-1:0] thresh_q
);

  localparam int ACC_W  = TH_W + FRM_LOG2 + 3;
  localparam int ERR_W  = TH_W + 2;
  localparam int PROD_W = ERR_W + $clog2(GAIN_NUM + 1) + 1;

  localparam logic        [TH_W-1:0]   FULL   = TH_W'(NPIX);
  localparam logic        [ACC_W-1:0]  FULL_A = ACC_W'(NPIX);
  localparam logic signed [PROD_W-1:0] FULL_S = PROD_W'(NPIX);
  localparam logic signed [PROD_W-1:0] GAIN_S = PROD_W'(GAIN_NUM);

  logic        [ACC_W-1:0]  acc_q;
  logic        [ACC_W-1:0]  sum;
  logic        [ACC_W-1:0]  avg_wide;
  logic        [TH_W-1:0]   avg;
  logic        [TH_W-1:0]   tgt_c;
  logic signed [ERR_W-1:0]  err;
  logic signed [PROD_W-1:0] err_ext;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] step;
  logic signed [PROD_W-1:0] nxt;
  logic        [TH_W-1:0]   thr_next;

  always_comb begin
    // A block shown in the closing cycle still belongs to the closing frame.
    sum      = acc_q + (cnt_valid ? ACC_W'(cnt) : '0);
    avg_wide = sum >> FRM_LOG2;
    avg      = (avg_wide > FULL_A) ? FULL : avg_wide[TH_W-1:0];
    tgt_c    = (target > FULL) ? FULL : target;
    err      = $signed({2'b00, tgt_c}) - $signed({2'b00, avg});
    err_ext  = {{(PROD_W-ERR_W){err[ERR_W-1]}}, err};
    prod     = err_ext * GAIN_S;
    step     = prod >>> GAIN_SHIFT;
    nxt      = $signed({{(PROD_W-TH_W){1'b0}}, thresh_q}) + step;
    if (nxt[PROD_W-1]) begin
      thr_next = '0;
    end else if (nxt > FULL_S) begin
      thr_next = FULL;
    end else begin
      thr_next = nxt[TH_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      thresh_q <= FULL;
    end else if (frame_end) begin
      acc_q    <= '0;
      thresh_q <= thr_next;
    end else begin
      acc_q    <= sum;
    end
  end

endmodule

// File: rtl/ssc_subsample_ctrl.sv
module ssc_subsample_ctrl #(
  parameter int BLK_DIM    = 16,
  parameter int NPIX       = BLK_DIM * BLK_DIM,
  parameter int TH_W       = $clog2(NPIX) + 1,
  parameter int FRM_LOG2   = 4,
  parameter int GAIN_NUM   = 13,
  parameter int GAIN_SHIFT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blk_valid_i,
  input  logic [NPIX-1:0] edge_map_i,
  input  logic [TH_W-1:0] target_i,
  input  logic            frame_end_i,
  output logic [NPIX-1:0] mask_o,
  output logic            mask_valid_o,
  output logic [TH_W-1:0] thresh_o
);

  logic [TH_W-1:0] kept;
  logic [TH_W-1:0] thresh;

  ssc_mask_stage #(.DIM(BLK_DIM), .NPIX(NPIX), .TH_W(TH_W)) u_mask (
    .clk       (clk),
    .rst       (rst),
    .blk_valid (blk_valid_i),
    .edge_map  (edge_map_i),
    .thresh    (thresh),
    .mask_q    (mask_o),
    .valid_q   (mask_valid_o),
    .kept_q    (kept)
  );

  ssc_loop_ctrl #(
    .NPIX       (NPIX),
    .TH_W       (TH_W),
    .FRM_LOG2   (FRM_LOG2),
    .GAIN_NUM   (GAIN_NUM),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) u_loop (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end_i),
    .cnt_valid (mask_valid_o),
    .cnt       (kept),
    .target    (target_i),
    .thresh_q  (thresh)
  );

  assign thresh_o = thresh;

endmodule

// File: rtl/ssc_subsample_ctrl_chk.sv
module ssc_subsample_ctrl_chk #(
  parameter int NPIX = 256,
  parameter int TH_W = 9
) (
  input logic            clk,
  input logic            rst,
  input logic            blk_valid_i,
  input logic [NPIX-1:0] edge_map_i,
  input logic            frame_end_i,
  input logic [NPIX-1:0] mask_o,
  input logic            mask_valid_o,
  input logic [TH_W-1:0] thresh_o
);

  localparam logic [TH_W-1:0] FULL = TH_W'(NPIX);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (thresh_o == FULL && !mask_valid_o));

  a_r2_edge_kept: assert property (@(posedge clk) disable iff (rst)
    mask_valid_o |-> ((mask_o & $past(edge_map_i)) == $past(edge_map_i)));

  a_r3_full_open: assert property (@(posedge clk) disable iff (rst)
    (mask_valid_o && $past(thresh_o) == FULL) |-> (&mask_o));

  a_r3_closed_edges_only: assert property (@(posedge clk) disable iff (rst)
    (mask_valid_o && $past(thresh_o) == '0) |-> (mask_o == $past(edge_map_i)));

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    blk_valid_i |=> mask_valid_o);

  a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !blk_valid_i |=> !mask_valid_o);

  a_r6_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
    !frame_end_i |=> $stable(thresh_o));

  a_r7_thresh_range: assert property (@(posedge clk) disable iff (rst)
    thresh_o <= FULL);

endmodule

bind ssc_subsample_ctrl ssc_subsample_ctrl_chk #(.NPIX(NPIX), .TH_W(TH_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .blk_valid_i  (blk_valid_i),
  .edge_map_i   (edge_map_i),
  .frame_end_i  (frame_end_i),
  .mask_o       (mask_o),
  .mask_valid_o (mask_valid_o),
  .thresh_o     (thresh_o)
);

// File: tb/ssc_subsample_ctrl_test.sv
module ssc_subsample_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DIM        = 16;
  localparam int NPIX       = DIM * DIM;
  localparam int TH_W       = 9;
  localparam int BPF        = 16;
  localparam int NPH        = 7;
  localparam int P4_LAST    = 199;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            blk_valid = 1'b0;
  logic [NPIX-1:0] edge_map = '0;
  logic [TH_W-1:0] target = 9'd240;
  logic            frame_end = 1'b0;
  logic [NPIX-1:0] mask_o;
  logic            mask_valid_o;
  logic [TH_W-1:0] thresh_o;

  ssc_subsample_ctrl uut (
    .clk          (clk),
    .rst          (rst),
    .blk_valid_i  (blk_valid),
    .edge_map_i   (edge_map),
    .target_i     (target),
    .frame_end_i  (frame_end),
    .mask_o       (mask_o),
    .mask_valid_o (mask_valid_o),
    .thresh_o     (thresh_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  // ---------------- behavioural reference ----------------
  int              m_th  = 256;
  int              m_acc = 0;
  logic            e_valid = 1'b0;
  logic [NPIX-1:0] e_mask  = '0;

  function automatic int rank_of(input int i);
    int r = i / DIM;
    int c = i % DIM;
    return ((r % 2) * 2 + (c % 2)) * (NPIX / 4) + (r / 2) * (DIM / 2) + c / 2;
  endfunction

  function automatic logic [NPIX-1:0] ref_mask(input logic [NPIX-1:0] e, input int th);
    logic [NPIX-1:0] m;
    for (int i = 0; i < NPIX; i++) m[i] = e[i] || (rank_of(i) < th);
    return m;
  endfunction

  function automatic logic [NPIX-1:0] even_grid();
    logic [NPIX-1:0] m;
    for (int i = 0; i < NPIX; i++) m[i] = ((i / DIM) % 2 == 0) && ((i % DIM) % 2 == 0);
    return m;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_th    = 256;
      m_acc   = 0;
      e_valid = 1'b0;
      e_mask  = '0;
    end else begin
      int add;
      int avg;
      int tg;
      int err;
      int nt;
      add = e_valid ? $countones(e_mask) : 0;
      if (blk_valid) e_mask = ref_mask(edge_map, m_th);
      e_valid = blk_valid;
      if (frame_end) begin
        avg = (m_acc + add) / BPF;
        if (avg > 256) avg = 256;
        tg  = (int'(target) > 256) ? 256 : int'(target);
        err = tg - avg;
        nt  = m_th + ((err * 13) >>> 6);
        if (nt < 0) nt = 0;
        if (nt > 256) nt = 256;
        m_th  = nt;
        m_acc = 0;
      end else begin
        m_acc = m_acc + add;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  int              obs_acc   = 0;
  int              obs_frame = 0;
  int              obs_avg[256];
  int              frm_tgt[256];
  int              frm_ph[256];
  int              frm_j[256];
  logic [NPIX-1:0] prev_edge = '0;

  task automatic tick(input bit v, input logic [NPIX-1:0] e, input bit fe, input int tg);
    @(negedge clk);
    chk(mask_valid_o == e_valid, "R4", "mask_valid",
        $sformatf("%0d", mask_valid_o), $sformatf("%0d", e_valid));
    if (e_valid) begin
      chk(mask_o == e_mask, "R3", "mask", $sformatf("%h", mask_o), $sformatf("%h", e_mask));
      chk((mask_o & prev_edge) == prev_edge, "R2", "edge bits",
          $sformatf("%h", mask_o & prev_edge), $sformatf("%h", prev_edge));
    end
    chk(int'(thresh_o) == m_th, (int'(target) > 256) ? "R8" : "R6", "threshold",
        $sformatf("%0d", thresh_o), $sformatf("%0d", m_th));
    chk(thresh_o <= 9'd256, "R7", "threshold bound",
        $sformatf("%0d", thresh_o), "<=256");
    if (mask_valid_o) begin
      obs_acc += $countones(mask_o);
      if (obs_frame == P4_LAST)
        chk(mask_o == even_grid(), "R10", "4-to-1 pattern",
            $sformatf("%h", mask_o), $sformatf("%h", even_grid()));
    end
    if (fe) begin
      obs_avg[obs_frame] = obs_acc / BPF;
      obs_acc = 0;
      obs_frame++;
    end
    blk_valid = v;
    edge_map  = e;
    frame_end = fe;
    target    = tg[TH_W-1:0];
    if (v) prev_edge = e;
  endtask

  function automatic logic [NPIX-1:0] gen_edges(input int mode);
    logic [NPIX-1:0] e;
    for (int w = 0; w < NPIX / 32; w++) e[w*32 +: 32] = $urandom;
    if (mode == 1) e = e & even_grid();
    if (mode == 2) e = '0;
    return e;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ph_n[NPH] = '{40, 40, 40, 40, 40, 8, 12};
    int ph_t[NPH] = '{240, 192, 144, 96, 64, 64, 400};
    int ph_m[NPH] = '{1, 1, 1, 1, 2, 0, 2};
    int ph_o[NPH] = '{0, 0, 0, 0, 0, 1, 1};
    int  cur_tg;
    int  fidx;
    bit  pending;
    int  dev;

    repeat (3) @(negedge clk);
    // R1: values held during reset
    chk(thresh_o == 9'd256, "R1", "reset threshold", $sformatf("%0d", thresh_o), "256");
    chk(mask_valid_o == 1'b0, "R1", "reset valid", $sformatf("%0d", mask_valid_o), "0");
    rst = 1'b0;

    cur_tg  = 240;
    fidx    = 0;
    pending = 1'b0;
    for (int p = 0; p < NPH; p++) begin
      for (int j = 0; j < ph_n[p]; j++) begin
        if (pending && ph_o[p] == 0) begin
          // close alone; still lands on the last block's mask_valid (R5)
          tick(1'b0, '0, 1'b1, cur_tg);
          pending = 1'b0;
        end
        frm_tgt[fidx] = ph_t[p];
        frm_ph[fidx]  = p;
        frm_j[fidx]   = j;
        for (int b = 0; b < BPF; b++) begin
          bit fe;
          if (b == 1) cur_tg = ph_t[p];
          fe = (b == 0) && pending;
          // overlapped close: next block built in the update cycle (R4, R5)
          tick(1'b1, gen_edges(ph_m[p]), fe, cur_tg);
          if (fe) pending = 1'b0;
        end
        pending = 1'b1;
        fidx++;
      end
    end
    tick(1'b0, '0, 1'b1, cur_tg);
    repeat (4) tick(1'b0, '0, 1'b0, cur_tg);

    chk(obs_frame == fidx, "R5", "frames closed",
        $sformatf("%0d", obs_frame), $sformatf("%0d", fidx));

    // R9: settling after each downward step of 48
    for (int f = 0; f < fidx; f++) begin
      if (frm_ph[f] <= 3 && frm_j[f] >= 10) begin
        dev = obs_avg[f] - frm_tgt[f];
        if (dev < 0) dev = -dev;
        chk(20 * dev <= frm_tgt[f], "R9", $sformatf("frame %0d average", f),
            $sformatf("%0d", obs_avg[f]), $sformatf("%0d+-5%%", frm_tgt[f]));
      end
    end
    chk(obs_avg[P4_LAST] == 64, "R10", "settled 4-to-1 average",
        $sformatf("%0d", obs_avg[P4_LAST]), "64");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule